// File: doc/BRIEF.md
# Bus Dominant-Level Wakeup and Fault Timers with Interrupt Registers

This block sits beside a single-wire LIN/CXPI physical interface and watches the received bus level. Two counters are advanced by rising edges of a slow clock. The wakeup counter runs while the interface is in a low-power state and the bus is held dominant. When it reaches its programmed edge count, it raises a wakeup request. The fault counter measures how long the bus stays dominant in any state. When the bus is stuck past its programmed limit, it raises a fault request. A thermal-shutdown status input forms a third interrupt source.

The slow clock, the bus level and the shutdown status all arrive asynchronously. Each one passes through a two-stage synchroniser. Software reaches the block through a small write/read register port. The port holds an enable word and two thresholds. It also holds a request register that is cleared by writing 1 to a bit, a register that forces requests, a mask, and a read-only masked view. Both running counts can be read back. When the physical interface is a CXPI slave, the wakeup threshold does not apply: the first dominant edge seen in a low-power state wakes the system at once.

Top module: `bwf_top`

## Requirements
- R1: After reset every register (enables, thresholds, requests, mask) and both counts read 0, and `irq` is 0.
- R2: With the wake enable (enable bit 0) set, `low_power` high, `cxpi_slave` low and the bus dominant (`bus_rx`=0), each rising edge of `lf_clk` adds 1 to the wake count. Request bit 0 is set when the count reaches the wake threshold (address 1). The count then stays at the threshold, so the request fires only once per dominant episode.
- R3: With the fault enable (enable bit 1) set and the bus dominant, each rising `lf_clk` edge adds 1 to the fault count, whatever the power state. Request bit 1 is set when the count reaches the fault threshold (address 2). The count then stays at the threshold.
- R4: Both counts return to 0 when the bus goes recessive or the timer's enable is cleared. A threshold of 0 never raises a request.
- R5: With `low_power` low or the wake enable clear, the wake count stays 0 and no wakeup request is raised.
- R6: With `cxpi_slave` high, the wake enable set and `low_power` high, a recessive-to-dominant bus edge sets request bit 0 at once. The wake count stays 0, whatever the threshold is.
- R7: A rising edge of the synchronised `tsd_in` sets request bit 2. A level that stays high does not set the bit again after software clears it.
- R8: Writing 1 to a bit of the request register (address 3) clears that bit. Writing 0 leaves the bit unchanged.
- R9: Writing 1 to a bit of the set register (address 4) sets the matching request bit. The set register reads as 0.
- R10: The masked view (address 6) equals request AND mask (address 5). `irq` is the OR of the masked bits.
- R11: If a hardware event and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R12: The wake count reads at address 7 and the fault count at address 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_clk | input | 1 | Slow clock; its rising edges are counted |
| bus_rx | input | 1 | Received bus level, 0 = dominant, asynchronous |
| tsd_in | input | 1 | Thermal-shutdown status, asynchronous |
| low_power | input | 1 | Interface is in a low-power state |
| cxpi_slave | input | 1 | Interface is configured as a CXPI slave |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of the masked requests |

## Verification
The hardest case to reach from the ports is R11. It needs a threshold hit and a software clear of the same request bit to land on exactly the same clock edge. That edge sits behind the two-stage synchroniser and the edge detector on `lf_clk`. The stimulus first forces the wakeup request with the set register and parks the wake count one below its threshold. It then raises `lf_clk` on a falling clock edge and lets two rising edges pass. Finally it presents the clear write so that the write lands on the third edge, which is the edge where the count reaches the threshold. Randomised episodes vary the thresholds, the enables, the power state and the number of slow edges, and each result is compared with the saturating count and the request the episode should produce.

// File: rtl/bwf_pkg.sv
package bwf_pkg;
  localparam int unsigned IRQ_N   = 3;
  localparam int unsigned IRQ_WAK = 0;
  localparam int unsigned IRQ_FLT = 1;
  localparam int unsigned IRQ_TSD = 2;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_WTHR   = 4'd1,
    RA_FTHR   = 4'd2,
    RA_REQ    = 4'd3,
    RA_SET    = 4'd4,
    RA_MASK   = 4'd5,
    RA_MASKED = 4'd6,
    RA_WCNT   = 4'd7,
    RA_FCNT   = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/bwf_sync.sv
module bwf_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= INIT;
      q  <= INIT;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/bwf_dom_timer.sv
module bwf_dom_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] thr,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  logic [CW-1:0] cnt_d;
  logic          below;
  logic          step;

  assign below = (cnt < thr);
  assign step  = run & tick & below;
  assign hit   = step & ((cnt + CW'(1)) == thr);

  always_comb begin
    cnt_d = cnt;
    if (!run)      cnt_d = '0;
    else if (step) cnt_d = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/bwf_irq.sv
module bwf_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wd,
  output logic [N-1:0] req,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] req_d;
  logic [N-1:0] mask_d;

  always_comb begin
    req_d  = (req & ~sw_clr) | sw_set | hw_set;
    mask_d = mask_we ? mask_wd : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= '0;
      mask <= '0;
    end else begin
      req  <= req_d;
      mask <= mask_d;
    end
  end

  assign irq = |(req & mask);
endmodule

// File: rtl/bwf_top.sv
module bwf_top
  import bwf_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lf_clk,
  input  logic          bus_rx,
  input  logic          tsd_in,
  input  logic          low_power,
  input  logic          cxpi_slave,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int unsigned NS = 3;

  logic [NS-1:0] sync_q;
  logic lf_s, bus_s, tsd_s;
  logic lf_q, bus_q, tsd_q;
  logic tick, dom_edge, tsd_rise;

  bwf_sync #(.W(NS), .INIT(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({tsd_in, bus_rx, lf_clk}), .q(sync_q)
  );
  assign lf_s  = sync_q[0];
  assign bus_s = sync_q[1];
  assign tsd_s = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_q  <= 1'b0;
      bus_q <= 1'b1;
      tsd_q <= 1'b0;
    end else begin
      lf_q  <= lf_s;
      bus_q <= bus_s;
      tsd_q <= tsd_s;
    end
  end

  assign tick     = lf_s & ~lf_q;
  assign dom_edge = bus_q & ~bus_s;
  assign tsd_rise = tsd_s & ~tsd_q;

  // configuration registers
  logic [1:0]    ctrl, ctrl_d;
  logic [DW-1:0] wthr, wthr_d, fthr, fthr_d;
  logic          wr_ctrl, wr_wthr, wr_fthr;

  assign wr_ctrl = reg_we && (reg_addr == AW'(RA_CTRL));
  assign wr_wthr = reg_we && (reg_addr == AW'(RA_WTHR));
  assign wr_fthr = reg_we && (reg_addr == AW'(RA_FTHR));

  always_comb begin
    ctrl_d = wr_ctrl ? reg_wdata[1:0] : ctrl;
    wthr_d = wr_wthr ? reg_wdata      : wthr;
    fthr_d = wr_fthr ? reg_wdata      : fthr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      wthr <= '0;
      fthr <= '0;
    end else begin
      ctrl <= ctrl_d;
      wthr <= wthr_d;
      fthr <= fthr_d;
    end
  end

  // timers
  logic          wake_en, fault_en, bus_dom;
  logic          wake_run, fault_run, cxpi_wake;
  logic [DW-1:0] wake_cnt, fault_cnt;
  logic          wake_hit, fault_hit;

  assign wake_en   = ctrl[0];
  assign fault_en  = ctrl[1];
  assign bus_dom   = ~bus_s;
  assign wake_run  = wake_en & low_power & ~cxpi_slave & bus_dom;
  assign fault_run = fault_en & bus_dom;
  assign cxpi_wake = wake_en & low_power & cxpi_slave & dom_edge;

  bwf_dom_timer #(.CW(DW)) u_wake (
    .clk(clk), .rst_n(rst_n), .run(wake_run), .tick(tick),
    .thr(wthr), .cnt(wake_cnt), .hit(wake_hit)
  );

  bwf_dom_timer #(.CW(DW)) u_fault (
    .clk(clk), .rst_n(rst_n), .run(fault_run), .tick(tick),
    .thr(fthr), .cnt(fault_cnt), .hit(fault_hit)
  );

  // interrupt registers
  logic [IRQ_N-1:0] hw_set, sw_set, clr_v, req, mask;
  logic             mask_we;

  assign hw_set[IRQ_WAK] = wake_hit | cxpi_wake;
  assign hw_set[IRQ_FLT] = fault_hit;
  assign hw_set[IRQ_TSD] = tsd_rise;
  assign sw_set  = (reg_we && reg_addr == AW'(RA_SET)) ? reg_wdata[IRQ_N-1:0] : '0;
  assign clr_v   = (reg_we && reg_addr == AW'(RA_REQ)) ? reg_wdata[IRQ_N-1:0] : '0;
  assign mask_we = reg_we && (reg_addr == AW'(RA_MASK));

  bwf_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_set(sw_set),
    .sw_clr(clr_v), .mask_we(mask_we), .mask_wd(reg_wdata[IRQ_N-1:0]),
    .req(req), .mask(mask), .irq(irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(RA_CTRL):   reg_rdata = DW'(ctrl);
      AW'(RA_WTHR):   reg_rdata = wthr;
      AW'(RA_FTHR):   reg_rdata = fthr;
      AW'(RA_REQ):    reg_rdata = DW'(req);
      AW'(RA_MASK):   reg_rdata = DW'(mask);
      AW'(RA_MASKED): reg_rdata = DW'(req & mask);
      AW'(RA_WCNT):   reg_rdata = wake_cnt;
      AW'(RA_FCNT):   reg_rdata = fault_cnt;
      default:        reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bwf_chk.sv
module bwf_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_s,
  input logic          tsd_s,
  input logic          cxpi_slave,
  input logic [DW-1:0] wake_cnt,
  input logic [DW-1:0] fault_cnt,
  input logic [2:0]    req,
  input logic [2:0]    hw_set,
  input logic [2:0]    clr_v
);
  // R4: a recessive bus empties both counters on the next edge
  a_r4_recessive_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_s |=> (wake_cnt == '0) && (fault_cnt == '0));

  // R2: the wake count only steps by one or falls back to zero
  a_r2_wake_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cnt != $past(wake_cnt)) |-> ((wake_cnt == $past(wake_cnt) + DW'(1)) || (wake_cnt == '0)));

  // R3: the fault count only steps by one or falls back to zero
  a_r3_fault_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cnt != $past(fault_cnt)) |-> ((fault_cnt == $past(fault_cnt) + DW'(1)) || (fault_cnt == '0)));

  // R6: a settled CXPI-slave configuration keeps the wake count at zero
  a_r6_cxpi_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cxpi_slave && $past(cxpi_slave)) |-> (wake_cnt == '0));

  // R7: a rising shutdown status leaves its request set
  a_r7_tsd_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsd_s) |=> req[2]);

  // R11: a hardware set beats a software clear of the same bit
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set[0] && clr_v[0]) |=> req[0]);
endmodule

bind bwf_top bwf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .tsd_s(tsd_s),
  .cxpi_slave(cxpi_slave), .wake_cnt(wake_cnt), .fault_cnt(fault_cnt),
  .req(req), .hw_set(hw_set), .clr_v(clr_v)
);

// File: tb/sim_bwf_top.sv
module sim_bwf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf_clk = 1'b0;
  logic        bus_rx = 1'b1;
  logic        tsd_in = 1'b0;
  logic        low_power = 1'b0;
  logic        cxpi_slave = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bwf_top u0 (
    .clk(clk), .rst_n(rst_n), .lf_clk(lf_clk), .bus_rx(bus_rx),
    .tsd_in(tsd_in), .low_power(low_power), .cxpi_slave(cxpi_slave),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic int exp_cnt(bit run, int n, int thr);
    if (!run) return 0;
    return (n < thr) ? n : thr;
  endfunction

  function automatic bit exp_req(bit run, int n, int thr);
    return run && (thr > 0) && (n >= thr);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic lf_pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lf_clk = 1'b1;
      repeat (4) @(negedge clk);
      lf_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      check("R1 reset reg", v, 16'd0);
    end
    check("R1 irq reset", {15'd0, irq}, 16'd0);

    // R2 directed wake count and saturation, R12 readback
    wr(4'd5, 16'd7);
    wr(4'd0, 16'd3);
    wr(4'd1, 16'd3);
    low_power = 1'b1;
    bus_rx = 1'b0; settle();
    lf_pulses(2);
    rd(4'd7, v); check("R12 wake count 2", v, 16'd2);
    rd(4'd3, v); check("R2 no req yet", v, 16'd0);
    lf_pulses(1);
    rd(4'd3, v); check("R2 wake req at thr", v, 16'd1);
    check("R10 irq on wake", {15'd0, irq}, 16'd1);
    lf_pulses(2);
    rd(4'd7, v); check("R2 count saturates", v, 16'd3);
    rd(4'd8, v); check("R4 fault thr zero holds 0", v, 16'd0);
    wr(4'd3, 16'd1);
    lf_pulses(2);
    rd(4'd3, v); check("R8 W1C and R2 once per episode", v, 16'd0);
    bus_rx = 1'b1; settle();
    rd(4'd7, v); check("R4 recessive clears wake", v, 16'd0);

    // R5 wake blocked outside low power; R3 fault counts anyway
    low_power = 1'b0;
    wr(4'd2, 16'd4);
    bus_rx = 1'b0; settle();
    lf_pulses(5);
    rd(4'd7, v); check("R5 no wake count", v, 16'd0);
    rd(4'd8, v); check("R3 fault saturates", v, 16'd4);
    rd(4'd3, v); check("R3 fault req only", v, 16'd2);
    wr(4'd0, 16'd1); settle();
    rd(4'd8, v); check("R4 disable clears fault", v, 16'd0);
    bus_rx = 1'b1; settle();
    wr(4'd3, 16'd7);
    wr(4'd0, 16'd3);

    // R6 CXPI slave wake on edge
    cxpi_slave = 1'b1; low_power = 1'b1; settle();
    bus_rx = 1'b0; settle();
    rd(4'd3, v); check("R6 immediate wake", v, 16'd1);
    lf_pulses(4);
    rd(4'd7, v); check("R6 count stays 0", v, 16'd0);
    bus_rx = 1'b1; settle();
    wr(4'd3, 16'd7);
    cxpi_slave = 1'b0; low_power = 1'b0;

    // R7 thermal edge
    tsd_in = 1'b1; settle();
    rd(4'd3, v); check("R7 tsd req", v, 16'd4);
    wr(4'd3, 16'd4); settle();
    rd(4'd3, v); check("R7 level no reset", v, 16'd0);
    tsd_in = 1'b0; settle();
    tsd_in = 1'b1; settle();
    rd(4'd3, v); check("R7 second edge", v, 16'd4);
    wr(4'd3, 16'd4);
    wr(4'd3, 16'd0);

    // R9 set register, R10 mask
    wr(4'd4, 16'd2);
    rd(4'd3, v); check("R9 set forces req", v, 16'd2);
    rd(4'd4, v); check("R9 set reads 0", v, 16'd0);
    wr(4'd5, 16'd5);
    rd(4'd6, v); check("R10 masked off", v, 16'd0);
    check("R10 irq off", {15'd0, irq}, 16'd0);
    wr(4'd5, 16'd7);
    rd(4'd6, v); check("R10 masked on", v, 16'd2);
    check("R10 irq on", {15'd0, irq}, 16'd1);
    wr(4'd3, 16'd7);

    // R11 hardware set and software clear in the same cycle
    wr(4'd0, 16'd1);
    wr(4'd1, 16'd3);
    low_power = 1'b1;
    bus_rx = 1'b0; settle();
    lf_pulses(2);
    wr(4'd4, 16'd1);
    @(negedge clk); lf_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 16'd1;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (3) @(negedge clk); lf_clk = 1'b0; settle();
    rd(4'd7, v); check("R11 count at thr", v, 16'd3);
    rd(4'd3, v); check("R11 set wins", v, 16'd1);
    bus_rx = 1'b1; settle();
    wr(4'd3, 16'd7);

    // random episodes for R2, R3, R5
    for (int it = 0; it < 24; it++) begin
      int tw, tf, n;
      bit ew, ef, lp, wrun;
      tw = 1 + int'($urandom_range(5));
      tf = 1 + int'($urandom_range(5));
      n  = int'($urandom_range(8));
      ew = 1'($urandom_range(1));
      ef = 1'($urandom_range(1));
      lp = 1'($urandom_range(1));
      wrun = ew & lp;
      wr(4'd1, 16'(tw));
      wr(4'd2, 16'(tf));
      wr(4'd0, {14'd0, ef, ew});
      low_power = lp;
      bus_rx = 1'b0; settle();
      lf_pulses(n);
      rd(4'd7, v); check("R2 R5 rnd wake count", v, 16'(exp_cnt(wrun, n, tw)));
      rd(4'd8, v); check("R3 rnd fault count", v, 16'(exp_cnt(ef, n, tf)));
      rd(4'd3, v); check("R2 R3 rnd req", v,
        {14'd0, exp_req(ef, n, tf), exp_req(wrun, n, tw)});
      bus_rx = 1'b1; settle();
      wr(4'd3, 16'd7);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule